// File: doc/BRIEF.md
# Receive Character Buffer with Per-Byte Error Status

This block sits between a serial receiver and the host register interface of a serial port. Each character the receiver delivers is stored together with three error flags: parity error, framing error and break. The flags stay attached to their byte through the whole buffer. The host sees the oldest entry, which is its byte and its flags, before it reads. A read pulse then removes that entry.

The buffer holds up to 16 entries when buffering is enabled. With buffering disabled it holds a single character, so it behaves like a plain receive holding register. A character that arrives when no room is left is dropped, and the stored entries are kept. The block then raises a sticky overrun flag, which stays set until the host reads the line status. A selectable fill threshold drives an interrupt request, and a synchronous flush empties the buffer in one cycle.

Top module: `rx_status_fifo`

## Requirements
- R1: Entries leave in the order they were written. While an entry is at the head, `rd_data` shows its byte and `rd_stat` shows its flags as written, with bit 0 = parity error, bit 1 = framing error and bit 2 = break.
- R2: With `fifo_en`=1 the buffer holds 16 entries. `count` gives the occupancy, and `full` is high exactly when `count` equals 16.
- R3: A write while `full` is high and no pop happens in the same cycle is discarded. The stored entries and `count` stay unchanged, and `overrun` goes high on the next cycle.
- R4: `overrun` stays high until a cycle with `lsr_read`=1. If a new overrun happens in the same cycle as `lsr_read`, `overrun` stays high.
- R5: With `fifo_en`=0 the buffer holds one entry. `full` is high at `count`=1, and a second write is treated as in R3.
- R6: `empty` is high and `data_avail` is low exactly when `count` is 0. While the buffer is empty, `rd_data` and `rd_stat` read 0.
- R7: `trig_irq` is high when `count` is at or above the level chosen by `trig_sel`: 0 → 1, 1 → 4, 2 → 8, 3 → 14. With `fifo_en`=0 the level is 1.
- R8: `flush` makes `count` 0 on the next cycle. A write in the same cycle is dropped and raises no overrun, and `overrun` is otherwise left as it was.
- R9: A pop of an empty buffer has no effect. A write and a pop in the same cycle on a full buffer are both performed, and `count` stays unchanged.
- R10: After reset `count` is 0, `empty` is 1, and `full`, `data_avail`, `overrun` and `trig_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-entry buffering, 0: single-entry holding register |
| trig_sel | input | 2 | Interrupt fill threshold select |
| flush | input | 1 | Synchronous clear of all entries |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Received byte |
| wr_stat | input | 3 | {break, framing, parity} flags of the byte |
| rd_pop | input | 1 | Host read of the data register, removes the head |
| lsr_read | input | 1 | Host read of the line status, clears overrun |
| rd_data | output | 8 | Byte at the head |
| rd_stat | output | 3 | Flags of the head byte |
| count | output | 5 | Occupancy |
| empty | output | 1 | No entries stored |
| full | output | 1 | No room for another entry |
| data_avail | output | 1 | At least one entry stored |
| overrun | output | 1 | Sticky overrun error |
| trig_irq | output | 1 | Occupancy at or above the threshold |

## Verification
Entries are written with a different flag pattern on each byte, so a byte paired with the wrong flags or read out of order is caught on the host side. Fills to each of the four thresholds, one entry short and then exactly at the level, separate an off-by-one compare from a wrong level decode. Writes against a full buffer are tried in both modes, alone, with a pop, with a status read and with a flush in the same cycle. These show whether a blocked byte overwrites stored data, whether the overrun flag is sticky, and how set and clear are ordered. Popping an empty buffer shows whether the pointers can be corrupted.

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3,
  parameter int DEPTH  = 16,
  parameter int TRIG0  = 1,
  parameter int TRIG1  = 4,
  parameter int TRIG2  = 8,
  parameter int TRIG3  = 14,
  localparam int ENT_W = DATA_W + STAT_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [1:0]        trig_sel,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic              rd_pop,
  input  logic              lsr_read,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full,
  output logic              data_avail,
  output logic              overrun,
  output logic              trig_irq
);
  // DEPTH must be a power of two: pointers wrap by overflow.
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cap, level;
  logic             do_pop, do_push, ovr_evt;

  assign cap        = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign empty      = (count == '0);
  assign full       = (count >= cap);
  assign data_avail = !empty;
  assign do_pop     = rd_pop && !empty && !flush;
  assign do_push    = wr_en && !flush && ((count < cap) || (do_pop && count == cap));
  assign ovr_evt    = wr_en && !flush && !do_push;

  assign {rd_stat, rd_data} = empty ? '0 : mem[rd_ptr];

  always_comb begin
    unique case (trig_sel)
      2'd0:    level = CNT_W'(TRIG0);
      2'd1:    level = CNT_W'(TRIG1);
      2'd2:    level = CNT_W'(TRIG2);
      default: level = CNT_W'(TRIG3);
    endcase
    if (!fifo_en) level = CNT_W'(1);
  end
  assign trig_irq = !empty && (count >= level);

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= {wr_stat, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        overrun <= 1'b0;
    else if (ovr_evt)  overrun <= 1'b1;
    else if (lsr_read) overrun <= 1'b0;
  end
endmodule

// File: rtl/rx_status_fifo_chk.sv
module rx_status_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             wr_en,
  input logic             rd_pop,
  input logic             lsr_read,
  input logic [7:0]       rd_data,
  input logic [2:0]       rd_stat,
  input logic [CNT_W-1:0] count,
  input logic             empty,
  input logic             full,
  input logic             data_avail,
  input logic             overrun,
  input logic             trig_irq
);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(wr_en && full && !flush));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_pop && !flush) |=> (overrun && $stable(count)));

  // R4
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !lsr_read) |=> overrun);

  // R6
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (rd_data == '0 && rd_stat == '0 && !data_avail));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R7
  trig_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_irq |-> data_avail);
endmodule

bind rx_status_fifo rx_status_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_pop(rd_pop),
  .lsr_read(lsr_read), .rd_data(rd_data), .rd_stat(rd_stat), .count(count),
  .empty(empty), .full(full), .data_avail(data_avail), .overrun(overrun),
  .trig_irq(trig_irq)
);

// File: tb/rx_status_fifo_tb_top.sv
module rx_status_fifo_tb_top;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, flush = 0, wr_en = 0, rd_pop = 0, lsr_read = 0;
  logic [1:0] trig_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [2:0] wr_stat = 0, rd_stat;
  logic [4:0] count;
  logic empty, full, data_avail, overrun, trig_irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_status_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel), .flush(flush),
    .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat), .rd_pop(rd_pop),
    .lsr_read(lsr_read), .rd_data(rd_data), .rd_stat(rd_stat), .count(count),
    .empty(empty), .full(full), .data_avail(data_avail), .overrun(overrun),
    .trig_irq(trig_irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit w, int d, int s, bit p, bit l, bit f);
    wr_en = w; wr_data = 8'(d); wr_stat = 3'(s); rd_pop = p; lsr_read = l; flush = f;
    @(negedge clk);
    wr_en = 0; rd_pop = 0; lsr_read = 0; flush = 0;
  endtask

  task automatic push(int d, int s); step(1, d, s, 0, 0, 0); endtask

  task automatic pop_expect(string req, int d, int s);
    check({req, " head data"}, rd_data, d);
    check({req, " head status"}, rd_stat, s);
    step(0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_reset();
    check("R10 count", count, 0);
    check("R10 empty", empty, 1);
    check("R10 full", full, 0);
    check("R10 data_avail", data_avail, 0);
    check("R10 overrun", overrun, 0);
    check("R10 trig_irq", trig_irq, 0);
    check("R6 empty rd_data", rd_data, 0);
  endtask

  task automatic t_order();
    push(8'hA5, 3'b001);
    push(8'h3C, 3'b010);
    push(8'hF0, 3'b100);
    check("R6 data_avail", data_avail, 1);
    check("R6 empty low", empty, 0);
    pop_expect("R1 first", 8'hA5, 3'b001);
    pop_expect("R1 second", 8'h3C, 3'b010);
    pop_expect("R1 third", 8'hF0, 3'b100);
    check("R6 drained empty", empty, 1);
    check("R6 drained stat", rd_stat, 0);
  endtask

  task automatic t_trigger();
    int lv[4] = '{1, 4, 8, 14};
    for (int k = 0; k < 4; k++) begin
      trig_sel = 2'(k);
      step(0, 0, 0, 0, 0, 1);
      for (int i = 0; i < lv[k] - 1; i++) push(i, 0);
      check($sformatf("R7 below level sel=%0d", k), trig_irq, 0);
      push(8'h11, 0);
      check($sformatf("R7 at level sel=%0d", k), trig_irq, 1);
    end
    step(0, 0, 0, 0, 0, 1);
    trig_sel = 0;
  endtask

  task automatic t_full_overrun();
    for (int i = 0; i < 16; i++) push(8'h40 + i, i % 8);
    check("R2 count 16", count, 16);
    check("R2 full", full, 1);
    push(8'hEE, 3'b111);
    check("R3 overrun set", overrun, 1);
    check("R3 count kept", count, 16);
    for (int i = 0; i < 16; i++) pop_expect("R3 kept entry", 8'h40 + i, i % 8);
    check("R4 sticky after drain", overrun, 1);
    step(0, 0, 0, 0, 1, 0);
    check("R4 cleared by status read", overrun, 0);
  endtask

  task automatic t_depth1();
    fifo_en = 0;
    trig_sel = 3;
    push(8'h5A, 3'b010);
    check("R5 full at one", full, 1);
    check("R5 count", count, 1);
    check("R7 depth-1 trigger", trig_irq, 1);
    push(8'h77, 3'b001);
    check("R5 overrun", overrun, 1);
    check("R5 count kept", count, 1);
    step(1, 8'h99, 0, 0, 1, 0);
    check("R4 set wins over clear", overrun, 1);
    step(0, 0, 0, 0, 1, 0);
    check("R4 clear", overrun, 0);
    pop_expect("R5 head kept", 8'h5A, 3'b010);
    check("R5 empty", empty, 1);
    fifo_en = 1;
    trig_sel = 0;
  endtask

  task automatic t_flush();
    for (int i = 0; i < 16; i++) push(i, 0);
    push(8'h01, 0);
    check("R8 overrun before flush", overrun, 1);
    step(1, 8'h22, 3'b011, 0, 0, 1);
    check("R8 count zero", count, 0);
    check("R8 empty", empty, 1);
    check("R8 overrun untouched", overrun, 1);
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) push(i, 0);
    step(1, 8'h22, 0, 0, 0, 1);
    check("R8 no overrun from dropped write", overrun, 0);
    check("R8 dropped write", count, 0);
  endtask

  task automatic t_pushpop();
    step(0, 0, 0, 1, 0, 0);
    check("R9 empty pop count", count, 0);
    push(8'h61, 3'b101);
    pop_expect("R9 after empty pop", 8'h61, 3'b101);
    for (int i = 0; i < 16; i++) push(8'h80 + i, i % 8);
    step(1, 8'hC3, 3'b110, 1, 0, 0);
    check("R9 count unchanged", count, 16);
    check("R9 no overrun", overrun, 0);
    for (int i = 1; i < 16; i++) pop_expect("R9 order", 8'h80 + i, i % 8);
    pop_expect("R9 new tail", 8'hC3, 3'b110);
    check("R9 empty after", empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger();
    t_full_overrun();
    t_depth1();
    t_flush();
    t_pushpop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule